// File: doc/BRIEF.md
# Buck Converter Protection Sequencer

This block supervises a synchronous buck controller entirely in the digital domain. Its inputs are comparator results that are already digital: feedback in the good window, feedback low, current limit, feedback high, junction hot, junction cooled, and supply lockout. It also takes an enable pin. From these it decides whether the high-side and low-side drivers may switch, whether the low-side switch must be forced on as a crowbar, and whether the open-drain power-good pin is pulled low. An up/down counter models the soft-start capacitor and supplies the ramping reference level.

On enable the reference ramps from zero to its nominal count, one step per prescaled clock tick. If current limit and undervoltage occur together, the drivers stop and the level makes a hiccup excursion: first up to 112 % of nominal, then down to the floor count that corresponds to 50 mV. Soft-start then begins again from the floor. Sustained overvoltage latches a crowbar that only an enable toggle or a supply lockout clears. Over-temperature stops switching, discharges the reference and lets the power-good pin float. A new soft-start begins once the junction-cooled flag is seen.

Top module: `buck_prot_seq`

## Requirements
- R1: During reset, and while `enable` is low, the block drives `hs_allow`=0, `ls_allow`=0 and `ls_force`=0, with `pg_pulldown`=1 and `ss_level` held at 0.
- R2: After `enable` goes high, `ss_level` climbs from 0 in steps of +1. Consecutive steps are exactly `CLK_DIV` clocks apart. The level stops at `SS_NOM` (default 100) and stays there. Both drivers are allowed for the whole of soft-start and regulation.
- R3: `pg_pulldown` stays at 1 throughout soft-start. In regulation it falls to 0 after the clock edge that samples `pg_flag` high for the `PG_CYCLES`th consecutive time (default 8).
- R4: When `pg_flag` is sampled low, the consecutive count restarts, and `pg_pulldown` is 1 again after that edge.
- R5: `ilim_flag` alone, or `uv_flag` alone, has no effect. Both sampled high together during soft-start or regulation start a hiccup.
- R6: During a hiccup both drivers are off. `ss_level` first rises to `SS_NOM*112/100` (112) and then falls to `SS_NOM*50/600` (8). Soft-start then resumes from that floor. While the overload remains, the hiccup repeats.
- R7: `ov_flag` must be sampled high on `OV_CYCLES` (default 6) consecutive edges before the crowbar engages. It engages at the edge after the last of those samples. Shorter pulses have no effect.
- R8: Once the crowbar is latched, `ls_force`=1, `hs_allow`=0, `ls_allow`=0 and `pg_pulldown`=1. This holds after `ov_flag` falls, until `enable` goes low or `uvlo_flag` is seen.
- R9: When `hot_flag` is sampled high, both drivers stop and `pg_pulldown`=0. `ss_level` is cleared to 0 one cycle later. The block waits until `cool_flag` is sampled high, then starts a new soft-start.
- R10: Priority runs from supply lockout, to over-temperature, to the overvoltage latch, to the hiccup. Lockout forces the drivers off and `pg_pulldown`=1, and clears the crowbar latch. A thermal event during a latched crowbar returns to the crowbar on recovery.
- R11: `ss_level` never exceeds 112. Each change is +1, -1 or a clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Converter enable; high starts soft-start |
| pg_flag | input | 1 | Feedback above the 91 % good level |
| uv_flag | input | 1 | Feedback more than 30 % below nominal |
| ilim_flag | input | 1 | Current limit active |
| ov_flag | input | 1 | Feedback above 117 % of nominal |
| hot_flag | input | 1 | Junction over-temperature |
| cool_flag | input | 1 | Junction has cooled by the hysteresis |
| uvlo_flag | input | 1 | Supply below lockout threshold |
| hs_allow | output | 1 | High-side driver may switch |
| ls_allow | output | 1 | Low-side driver may switch |
| ls_force | output | 1 | Low-side switch forced on (crowbar) |
| pg_pulldown | output | 1 | Open-drain power-good pulldown active |
| ss_level | output | SS_W | Soft-start reference level |

## Verification
The assertions assume that the flags are synchronous to `clk` and change only between edges. They also assume that a hold property tied to the present values of `enable`, `uvlo_flag` and `hot_flag` sees the next state those values produce. The stimulus meets both assumptions: it drives every flag at the falling edge and holds it across at least one rising edge. Flag pulses are swept by length around the power-good and overvoltage qualification lengths. The overload and thermal flags are driven only while the block is in regulation or in a latched crowbar, so that each priority case is entered from a known state.

// File: rtl/prot_pkg.sv
// Shared types for the protection sequencer.
// Assumes: used by every module of the block; holds no logic.
package prot_pkg;
    typedef enum logic [2:0] {
        ST_OFF,   // disabled by enable low
        ST_SOFT,  // reference ramping up toward nominal
        ST_RUN,   // regulating
        ST_HUP,   // hiccup, rising leg
        ST_HDN,   // hiccup, falling leg
        ST_HOT,   // thermal shutdown
        ST_CROW,  // overvoltage crowbar latched
        ST_LOCK   // supply lockout
    } prot_state_t;

    typedef enum logic [1:0] {
        RC_HOLD,
        RC_UP,
        RC_DOWN,
        RC_CLEAR
    } ramp_cmd_t;
endpackage

// File: rtl/prot_tick.sv
// Prescaler: emits a one-cycle tick every DIV clocks, free-running.
// Assumes: DIV >= 1; with DIV == 1 every cycle is a tick.
module prot_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;
            // Count 0..DIV-1 and wrap.
            always_ff @(posedge clk) begin
                if (!rst_n)          cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                 cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/prot_qual.sv
// Consecutive-sample qualifier: ok goes high once flag has been sampled
// high on LEN consecutive edges, and drops at the first low sample.
// Assumes: flag is synchronous to clk; LEN >= 1.
module prot_qual #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic ok
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    logic [CW-1:0] cnt;

    // Saturating run-length counter of high samples.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!flag)      cnt <= '0;
        else if (cnt != FULL) cnt <= cnt + 1'b1;
    end

    assign ok = (cnt == FULL);
endmodule

// File: rtl/prot_ramp.sv
// Soft-start level counter: moves one count per tick in the commanded
// direction, or clears at once.
// Assumes: the caller stops commanding a direction at its target.
module prot_ramp
    import prot_pkg::*;
#(
    parameter int W    = 8,
    parameter int MAXV = 112
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  ramp_cmd_t    cmd,
    output logic [W-1:0] level
);
    localparam logic [W-1:0] MAX_C = W'(MAXV);

    // Step, hold or clear the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case (cmd)
                RC_CLEAR: level <= '0;
                RC_UP:    if (tick && level != MAX_C) level <= level + 1'b1;
                RC_DOWN:  if (tick && level != '0)    level <= level - 1'b1;
                default:  level <= level;
            endcase
        end
    end
endmodule

// File: rtl/prot_fsm.sv
// Protection state machine: picks the operating state from the fault
// flags and the soft-start level. It drives the ramp command and the
// gate and power-good controls.
// Assumes: ov_ok and pg_ok come from qualifiers on the same clock; the
// level input is the registered ramp output.
module prot_fsm
    import prot_pkg::*;
#(
    parameter int W     = 8,
    parameter int NOM   = 100,
    parameter int TOP   = 112,
    parameter int FLOOR = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         uvlo,
    input  logic         hot,
    input  logic         cool,
    input  logic         uv_hit,
    input  logic         ov_ok,
    input  logic         pg_ok,
    input  logic [W-1:0] level,
    output ramp_cmd_t    cmd,
    output logic         hs_allow,
    output logic         ls_allow,
    output logic         ls_force,
    output logic         pg_pulldown
);
    localparam logic [W-1:0] NOM_C   = W'(NOM);
    localparam logic [W-1:0] TOP_C   = W'(TOP);
    localparam logic [W-1:0] FLOOR_C = W'(FLOOR);

    prot_state_t st, nxt;
    logic        crow_q;
    logic        ov_watch;

    assign ov_watch = (st == ST_SOFT) || (st == ST_RUN) ||
                      (st == ST_HUP)  || (st == ST_HDN);

    // Next state: faults in priority order, then normal sequencing.
    always_comb begin
        nxt = st;
        if (uvlo)                       nxt = ST_LOCK;
        else if (!en)                   nxt = ST_OFF;
        else if (hot)                   nxt = ST_HOT;
        else if (st == ST_HOT)          nxt = cool ? (crow_q ? ST_CROW : ST_SOFT) : ST_HOT;
        else if (crow_q || (ov_ok && ov_watch)) nxt = ST_CROW;
        else if (uv_hit && (st == ST_SOFT || st == ST_RUN)) nxt = ST_HUP;
        else begin
            unique case (st)
                ST_OFF:  nxt = ST_SOFT;
                ST_LOCK: nxt = ST_SOFT;
                ST_SOFT: nxt = (level >= NOM_C) ? ST_RUN : ST_SOFT;
                ST_HUP:  nxt = (level >= TOP_C) ? ST_HDN : ST_HUP;
                ST_HDN:  nxt = (level <= FLOOR_C) ? ST_SOFT : ST_HDN;
                default: nxt = st;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    // Crowbar memory: survives a thermal event, cleared by lockout or enable low.
    always_ff @(posedge clk) begin
        if (!rst_n || uvlo || !en) crow_q <= 1'b0;
        else if (st == ST_CROW)    crow_q <= 1'b1;
    end

    // Ramp command per state.
    always_comb begin
        unique case (st)
            ST_SOFT: cmd = (level < NOM_C)   ? RC_UP   : RC_HOLD;
            ST_HUP:  cmd = (level < TOP_C)   ? RC_UP   : RC_HOLD;
            ST_HDN:  cmd = (level > FLOOR_C) ? RC_DOWN : RC_HOLD;
            ST_RUN:  cmd = RC_HOLD;
            default: cmd = RC_CLEAR;
        endcase
    end

    // Gate and power-good controls decoded from the state.
    always_comb begin
        hs_allow    = (st == ST_SOFT) || (st == ST_RUN);
        ls_allow    = hs_allow;
        ls_force    = (st == ST_CROW);
        pg_pulldown = (st == ST_HOT) ? 1'b0 : !((st == ST_RUN) && pg_ok);
    end
endmodule

// File: rtl/buck_prot_seq.sv
// Top of the protection sequencer: prescaler, two qualifiers, the
// soft-start counter and the state machine.
// Assumes: all flags are synchronous to clk; SS_NOM*112/100 fits in SS_W bits.
module buck_prot_seq #(
    parameter int SS_W      = 8,
    parameter int SS_NOM    = 100,
    parameter int CLK_DIV   = 2,
    parameter int PG_CYCLES = 8,
    parameter int OV_CYCLES = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            pg_flag,
    input  logic            uv_flag,
    input  logic            ilim_flag,
    input  logic            ov_flag,
    input  logic            hot_flag,
    input  logic            cool_flag,
    input  logic            uvlo_flag,
    output logic            hs_allow,
    output logic            ls_allow,
    output logic            ls_force,
    output logic            pg_pulldown,
    output logic [SS_W-1:0] ss_level
);
    import prot_pkg::*;

    localparam int SS_TOP   = SS_NOM * 112 / 100;
    localparam int SS_FLOOR = SS_NOM * 50 / 600;

    logic      tick;
    logic      pg_ok;
    logic      ov_ok;
    ramp_cmd_t cmd;

    prot_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    prot_qual #(.LEN(PG_CYCLES)) u_pgq (
        .clk(clk), .rst_n(rst_n), .flag(pg_flag), .ok(pg_ok)
    );

    prot_qual #(.LEN(OV_CYCLES)) u_ovq (
        .clk(clk), .rst_n(rst_n), .flag(ov_flag), .ok(ov_ok)
    );

    prot_ramp #(.W(SS_W), .MAXV(SS_TOP)) u_ramp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd), .level(ss_level)
    );

    prot_fsm #(.W(SS_W), .NOM(SS_NOM), .TOP(SS_TOP), .FLOOR(SS_FLOOR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(enable), .uvlo(uvlo_flag),
        .hot(hot_flag), .cool(cool_flag), .uv_hit(uv_flag & ilim_flag),
        .ov_ok(ov_ok), .pg_ok(pg_ok), .level(ss_level), .cmd(cmd),
        .hs_allow(hs_allow), .ls_allow(ls_allow), .ls_force(ls_force),
        .pg_pulldown(pg_pulldown)
    );
endmodule

// File: rtl/prot_checker.sv
// Property checker for buck_prot_seq, bound to every instance.
// Assumes: inputs change only between clock edges.
module prot_checker #(
    parameter int SS_W      = 8,
    parameter int SS_NOM    = 100,
    parameter int PG_CYCLES = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            pg_flag,
    input logic            hot_flag,
    input logic            uvlo_flag,
    input logic            hs_allow,
    input logic            ls_allow,
    input logic            ls_force,
    input logic            pg_pulldown,
    input logic [SS_W-1:0] ss_level
);
    localparam int TOPV = SS_NOM * 112 / 100;
    localparam int PCW  = $clog2(PG_CYCLES + 1);
    localparam logic [PCW-1:0] PG_FULL = PCW'(PG_CYCLES);

    logic [PCW-1:0] pg_run;

    // Independent run-length count of good feedback samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !pg_flag) pg_run <= '0;
        else if (pg_run != PG_FULL) pg_run <= pg_run + 1'b1;
    end

    a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ss_level <= SS_W'(TOPV));

    a_r11_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_level != $past(ss_level)) |->
        (ss_level == $past(ss_level) + 1'b1 || ss_level == $past(ss_level) - 1'b1 ||
         ss_level == '0));

    a_r8_crowbar_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_force && enable && !uvlo_flag && !hot_flag) |=> ls_force);

    a_r8_crowbar_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ls_force |-> (!hs_allow && !ls_allow && pg_pulldown));

    a_r10_lockout_off: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_flag |=> (!hs_allow && !ls_allow && !ls_force && pg_pulldown));

    a_r9_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_flag && enable && !uvlo_flag) |=>
        (!hs_allow && !ls_allow && !ls_force && !pg_pulldown));

    a_r3_pg_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_pulldown && hs_allow) |-> (pg_run == PG_FULL));
endmodule

bind buck_prot_seq prot_checker #(
    .SS_W(SS_W), .SS_NOM(SS_NOM), .PG_CYCLES(PG_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pg_flag(pg_flag),
    .hot_flag(hot_flag), .uvlo_flag(uvlo_flag), .hs_allow(hs_allow),
    .ls_allow(ls_allow), .ls_force(ls_force), .pg_pulldown(pg_pulldown),
    .ss_level(ss_level)
);

// File: tb/tb_buck_prot_seq.sv
// Self-checking bench for buck_prot_seq: sweeps pulse lengths and the
// fault cases with expected values worked out from the requirements.
module tb_buck_prot_seq;
    localparam int CLK_P  = 10;
    localparam int SS_W   = 8;
    localparam int NOM    = 100;
    localparam int DIV    = 2;
    localparam int PGN    = 8;
    localparam int OVN    = 6;
    localparam int TOP    = NOM * 112 / 100;
    localparam int FLOOR  = NOM * 50 / 600;

    logic clk = 1'b0;
    logic rst_n, enable, pg_flag, uv_flag, ilim_flag, ov_flag;
    logic hot_flag, cool_flag, uvlo_flag;
    logic hs_allow, ls_allow, ls_force, pg_pulldown;
    logic [SS_W-1:0] ss_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    buck_prot_seq #(.SS_W(SS_W), .SS_NOM(NOM), .CLK_DIV(DIV),
                    .PG_CYCLES(PGN), .OV_CYCLES(OVN)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pg_flag(pg_flag),
        .uv_flag(uv_flag), .ilim_flag(ilim_flag), .ov_flag(ov_flag),
        .hot_flag(hot_flag), .cool_flag(cool_flag), .uvlo_flag(uvlo_flag),
        .hs_allow(hs_allow), .ls_allow(ls_allow), .ls_force(ls_force),
        .pg_pulldown(pg_pulldown), .ss_level(ss_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_reg(input string req);
        int n = 0;
        while (!(hs_allow && ss_level == SS_W'(NOM)) && n < 5000) begin
            step();
            n++;
        end
        chk(n < 5000, req, int'(ss_level), NOM);
        step();
        step();
    endtask

    // Watchdog: counts as a failed check, then reports.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; enable = 0; pg_flag = 1; uv_flag = 0; ilim_flag = 0;
        ov_flag = 0; hot_flag = 0; cool_flag = 0; uvlo_flag = 0;
        repeat (3) step();
        chk(!hs_allow && !ls_allow && !ls_force && pg_pulldown && ss_level == 0,
            "R1 reset", int'(ss_level), 0);
        rst_n = 1;
        repeat (6) step();
        chk(!hs_allow && !ls_force && pg_pulldown && ss_level == 0,
            "R1 enable low", int'(hs_allow), 0);

        // R2: soft-start ramp, step size and spacing; R3 pulldown held.
        begin
            int last_chg = -1, gap_bad = 0, step_bad = 0, pg_bad = 0, cyc = 0;
            int prev = 0;
            enable = 1;
            while (ss_level != SS_W'(NOM) && cyc < 2000) begin
                step();
                cyc++;
                if (int'(ss_level) != prev) begin
                    if (int'(ss_level) != prev + 1) step_bad++;
                    if (last_chg >= 0 && cyc - last_chg != DIV) gap_bad++;
                    last_chg = cyc;
                    prev = int'(ss_level);
                end
                if (!pg_pulldown || !hs_allow || !ls_allow) pg_bad++;
            end
            chk(step_bad == 0, "R2 unit steps", step_bad, 0);
            chk(gap_bad == 0, "R2 step spacing", gap_bad, 0);
            chk(pg_bad == 0, "R3 pulldown during soft-start", pg_bad, 0);
            repeat (10) step();
            chk(ss_level == SS_W'(NOM) && hs_allow, "R2 hold at nominal", int'(ss_level), NOM);
            chk(!pg_pulldown, "R3 released in regulation", int'(pg_pulldown), 0);
        end

        // R3/R4: sweep good-feedback run lengths.
        for (int n = 1; n <= 12; n++) begin
            pg_flag = 0;
            step();
            chk(pg_pulldown, "R4 drop pulls low", int'(pg_pulldown), 1);
            pg_flag = 1;
            for (int k = 1; k <= n; k++) begin
                step();
                chk(pg_pulldown == (k < PGN), "R3 release timing", int'(pg_pulldown), int'(k < PGN));
            end
            pg_flag = 0;
            step();
            chk(pg_pulldown, "R4 counter restart", int'(pg_pulldown), 1);
        end
        pg_flag = 1;
        repeat (PGN + 1) step();

        // R7/R8/R10: overvoltage pulse sweep and latch release.
        for (int n = 1; n <= 8; n++) begin
            ov_flag = 1;
            for (int k = 1; k <= n; k++) begin
                step();
                chk(ls_force == (k >= OVN + 1), "R7 qualification", int'(ls_force), int'(k >= OVN + 1));
            end
            ov_flag = 0;
            for (int j = 1; j <= 3; j++) begin
                step();
                chk(ls_force == (n >= OVN), "R7 pulse length", int'(ls_force), int'(n >= OVN));
            end
            if (n >= OVN) begin
                repeat (20) step();
                chk(ls_force && !hs_allow && !ls_allow && pg_pulldown,
                    "R8 latch holds", int'(ls_force), 1);
                if (n % 2 == 0) begin
                    uvlo_flag = 1;
                    step();
                    chk(!ls_force && pg_pulldown, "R10 lockout clears latch", int'(ls_force), 0);
                    uvlo_flag = 0;
                end else begin
                    enable = 0;
                    step();
                    chk(!ls_force, "R8 enable clears latch", int'(ls_force), 0);
                    enable = 1;
                end
                wait_reg("R8 restart");
                repeat (PGN) step();
            end else begin
                chk(hs_allow, "R7 short pulse ignored", int'(hs_allow), 1);
            end
        end

        // R5: single overload flags are ignored.
        ilim_flag = 1;
        repeat (3) step();
        chk(hs_allow && ss_level == SS_W'(NOM), "R5 current limit alone", int'(hs_allow), 1);
        ilim_flag = 0; uv_flag = 1;
        repeat (3) step();
        chk(hs_allow && ss_level == SS_W'(NOM), "R5 undervoltage alone", int'(hs_allow), 1);

        // R6: one hiccup excursion.
        begin
            int mx = 0, mn = 1000, n = 0, gate_bad = 0;
            ilim_flag = 1;
            step();
            ilim_flag = 0; uv_flag = 0;
            chk(!hs_allow && !ls_allow, "R5 both flags trip", int'(hs_allow), 0);
            while (!hs_allow && n < 3000) begin
                if (int'(ss_level) > mx) mx = int'(ss_level);
                if (int'(ss_level) < mn) mn = int'(ss_level);
                if (ls_allow || ls_force) gate_bad++;
                step();
                n++;
            end
            chk(mx == TOP, "R6 hiccup peak", mx, TOP);
            chk(mn == FLOOR, "R6 hiccup floor", mn, FLOOR);
            chk(int'(ss_level) == FLOOR, "R6 restart level", int'(ss_level), FLOOR);
            chk(gate_bad == 0, "R6 gates off", gate_bad, 0);
            wait_reg("R6 recovery");
        end

        // R6: persistent overload repeats.
        begin
            int falls = 0;
            logic prev_hs = 1'b1;
            ilim_flag = 1; uv_flag = 1;
            for (int i = 0; i < 1000; i++) begin
                step();
                if (prev_hs && !hs_allow) falls++;
                prev_hs = hs_allow;
            end
            chk(falls >= 2, "R6 repeated hiccup", falls, 2);
            ilim_flag = 0; uv_flag = 0;
            wait_reg("R6 overload removed");
        end

        // R9: thermal shutdown and recovery.
        hot_flag = 1;
        step();
        chk(!hs_allow && !ls_allow && !ls_force && !pg_pulldown, "R9 thermal stop",
            int'(pg_pulldown), 0);
        step();
        chk(ss_level == 0, "R9 discharge", int'(ss_level), 0);
        hot_flag = 0;
        repeat (5) step();
        chk(!hs_allow && ss_level == 0, "R9 waits for cool", int'(hs_allow), 0);
        cool_flag = 1;
        step();
        cool_flag = 0;
        chk(hs_allow && ss_level <= 1, "R9 new soft-start", int'(ss_level), 0);
        wait_reg("R9 recovery");
        repeat (PGN) step();

        // R10: thermal inside crowbar returns to crowbar; lockout beats thermal.
        ov_flag = 1;
        repeat (OVN + 2) step();
        ov_flag = 0;
        chk(ls_force, "R10 crowbar set", int'(ls_force), 1);
        hot_flag = 1;
        step();
        chk(!ls_force && !pg_pulldown, "R10 thermal over crowbar", int'(ls_force), 0);
        hot_flag = 0; cool_flag = 1;
        step();
        cool_flag = 0;
        chk(ls_force, "R10 crowbar after cooling", int'(ls_force), 1);
        hot_flag = 1;
        step();
        uvlo_flag = 1;
        step();
        chk(pg_pulldown && !ls_force && !hs_allow, "R10 lockout over thermal",
            int'(pg_pulldown), 1);
        uvlo_flag = 0; hot_flag = 0;
        wait_reg("R10 lockout recovery");
        chk(!ls_force, "R10 latch cleared", int'(ls_force), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule